// File: doc/BRIEF.md
# Programmable Clock Post-Divider with Request Gating

This block derives a slower clock from a fast source clock by an integer factor between 1 and 31. It does not build a second clock tree. It produces a one-cycle clock-enable pulse at the start of every output period, plus a level signal that shows the shape of the divided clock. Software controls it through one 32-bit control and status word. Writes go through a single-cycle write strobe, and the word can always be read on a combinational read bus.

Software can change the factor at any time. A new factor waits in the control word until the running period has finished, so the output never has a truncated phase. A toggling acknowledge bit tells software that the new factor is now in use. The output runs under one of two rules. In the first, a force bit keeps it running. In the second, it follows a downstream request and stops at the end of a complete period once the request drops. A power-down bit picks what the divider counter does while the output is stopped: it either keeps counting, or it is held in reset so that the first period after waking is a full one.

The register port and the request are control signals. They have no valid/ready handshake and no back-pressure: a write is taken in every cycle in which the strobe is high.

Top module: `clk_postdiv`

## Requirements
- R1: After reset the word reads 0x00000004: factor 4, acknowledge 0, force 0, status 0 (running), power-down 0.
- R2: Bits 4:0 hold the factor N, which reads back exactly as written. With the output running, clk_en_o pulses once every N source cycles for N from 1 to 31. A written 0 reads back as 0 and divides by 1.
- R3: div_clk_o is high for the first floor(N/2) cycles of each period, beginning with the pulse cycle, and is low for the rest of the period. For N of 1 it stays low.
- R4: Bit 5 toggles once when a newly written factor starts its first period. A write whose effective factor equals the previously written one causes no toggle. Several such writes inside one period cause one toggle.
- R5: With bit 8 set, the output keeps running while clk_req is low.
- R6: With bit 8 clear and clk_req low, the output stops at the end of the current period, within N cycles. Bit 9 then reads 1, and no pulse appears while it is 1.
- R7: With bit 12 clear, the counter keeps running while the output is stopped. A rising request restarts the output at a period boundary, between 1 and N cycles later.
- R8: With bit 12 set, the counter is held at zero while the output is stopped. A request restarts the output with a pulse in the next cycle, followed by a full period.
- R9: Bits 31:13, 11:10 and 7:6 read as 0 and ignore writes.
- R10: While the divider is powered down, a pending factor takes effect in the next cycle, and bit 5 toggles even though the output is stopped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast source clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 32 | Data written to the control word |
| rd_data | output | 32 | Current control and status word |
| clk_req | input | 1 | Downstream request for the output clock |
| clk_en_o | output | 1 | One-cycle pulse at the start of each output period |
| div_clk_o | output | 1 | Level form of the divided clock |

## Verification
The bench builds the block with its default 5-bit factor field and reset factor 4. This makes the full factor range reachable, including the extremes 1 and 31 and the written-0 case. A vector table sweeps factors that differ in parity and size while the force bit is set, and checks the period length, the high-phase length and the acknowledge count for each one. Directed tests then cover each gating mode with the power-down bit both clear and set, a write of an unchanged factor, two writes inside one period, and a factor change while the divider is powered down.

// File: rtl/postdiv_pkg.sv
package postdiv_pkg;
  localparam int WORD_W    = 32;
  localparam int DIV_W     = 5;
  localparam int DIV_LSB   = 0;
  localparam int ACK_BIT   = 5;
  localparam int FORCE_BIT = 8;
  localparam int GATED_BIT = 9;
  localparam int PWDN_BIT  = 12;

  typedef struct packed {
    logic [DIV_W-1:0] div;
    logic             force_on;
    logic             auto_pwdn;
  } ctrl_t;

  // Factor in use: a raw 0 divides by 1
  function automatic logic [DIV_W-1:0] eff_div(input logic [DIV_W-1:0] raw);
    return (raw == '0) ? DIV_W'(1) : raw;
  endfunction
endpackage

// File: rtl/postdiv_regs.sv
module postdiv_regs
  import postdiv_pkg::*;
#(
  parameter int DIV_RST = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  output ctrl_t             ctrl,
  output logic              new_div
);
  logic [DIV_W-1:0] wr_div;
  assign wr_div  = wr_data[DIV_LSB +: DIV_W];
  // A write arms an update only if the effective factor changes
  assign new_div = wr_en && (eff_div(wr_div) != eff_div(ctrl.div));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl.div       <= DIV_W'(DIV_RST);
      ctrl.force_on  <= 1'b0;
      ctrl.auto_pwdn <= 1'b0;
    end else if (wr_en) begin
      ctrl.div       <= wr_div;
      ctrl.force_on  <= wr_data[FORCE_BIT];
      ctrl.auto_pwdn <= wr_data[PWDN_BIT];
    end
  end
endmodule

// File: rtl/postdiv_counter.sv
module postdiv_counter
  import postdiv_pkg::*;
#(
  parameter int DIV_RST = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_req,
  input  logic             new_div,
  input  logic             pwr_down,
  output logic [DIV_W-1:0] cnt,
  output logic [DIV_W-1:0] active,
  output logic             ack,
  output logic             boundary
);
  localparam logic [DIV_W-1:0] ONE = DIV_W'(1);
  logic pend;

  // Period end; while powered down every cycle counts as one
  assign boundary = pwr_down || (cnt == active - ONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt    <= '0;
      active <= DIV_W'(DIV_RST);
      pend   <= 1'b0;
      ack    <= 1'b0;
    end else begin
      cnt <= boundary ? '0 : cnt + ONE;
      if (boundary && pend) begin
        active <= eff_div(div_req);
        ack    <= ~ack;
        pend   <= new_div;
      end else if (new_div) begin
        pend <= 1'b1;
      end
    end
  end

  // R2
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < active);
  // R2
  div_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active != '0);
  // R4
  ack_at_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack != $past(ack)) |-> $past(boundary && pend));
endmodule

// File: rtl/postdiv_gate.sv
module postdiv_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic want,
  input  logic boundary,
  output logic gated
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gated <= 1'b0;
    end else if (boundary) begin
      gated <= !want;
    end
  end

  // R6
  close_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gated) |-> $past(boundary && !want));
  // R7
  open_on_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(gated) |-> $past(want && boundary));
endmodule

// File: rtl/clk_postdiv.sv
module clk_postdiv
  import postdiv_pkg::*;
#(
  parameter int DIV_RST = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  output logic [WORD_W-1:0] rd_data,
  input  logic              clk_req,
  output logic              clk_en_o,
  output logic              div_clk_o
);
  ctrl_t            ctrl;
  logic             new_div, pwr_down, boundary, gated, ack;
  logic [DIV_W-1:0] cnt, active;

  postdiv_regs #(.DIV_RST(DIV_RST)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .ctrl(ctrl), .new_div(new_div)
  );

  postdiv_counter #(.DIV_RST(DIV_RST)) u_cnt (
    .clk(clk), .rst_n(rst_n), .div_req(ctrl.div), .new_div(new_div),
    .pwr_down(pwr_down), .cnt(cnt), .active(active), .ack(ack),
    .boundary(boundary)
  );

  postdiv_gate u_gate (
    .clk(clk), .rst_n(rst_n), .want(ctrl.force_on || clk_req),
    .boundary(boundary), .gated(gated)
  );

  assign pwr_down  = gated && ctrl.auto_pwdn;
  assign clk_en_o  = !gated && (cnt == '0);
  assign div_clk_o = !gated && (cnt < (active >> 1));

  always_comb begin
    rd_data                      = '0;
    rd_data[DIV_LSB +: DIV_W]    = ctrl.div;
    rd_data[ACK_BIT]             = ack;
    rd_data[FORCE_BIT]           = ctrl.force_on;
    rd_data[GATED_BIT]           = gated;
    rd_data[PWDN_BIT]            = ctrl.auto_pwdn;
  end

  // R8
  pwdn_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_down |=> (cnt == '0));
endmodule

// File: tb/sim_clk_postdiv.sv
`timescale 1ns/1ps
module sim_clk_postdiv;
  logic        clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, clk_req = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        clk_en_o, div_clk_o;
  int          n_run = 0, n_fail = 0, toggles = 0;
  logic        prev_ack = 1'b0;

  // {factor[15:11], period[10:5], high cycles[4:0]}
  localparam logic [15:0] VEC [8] = '{
    {5'd7,  6'd7,  5'd3}, {5'd1,  6'd1,  5'd0},
    {5'd2,  6'd2,  5'd1}, {5'd3,  6'd3,  5'd1},
    {5'd31, 6'd31, 5'd15},{5'd0,  6'd1,  5'd0},
    {5'd16, 6'd16, 5'd8}, {5'd5,  6'd5,  5'd2}
  };

  clk_postdiv u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .clk_req(clk_req), .clk_en_o(clk_en_o),
    .div_clk_o(div_clk_o)
  );

  always #4 clk = ~clk;

  always @(negedge clk) if (rst_n) begin
    if (rd_data[5] !== prev_ack) toggles++;
    prev_ack = rd_data[5];
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [31:0] word(input logic [4:0] d, input logic f, input logic p);
    return {19'b0, p, 3'b0, f, 3'b0, d};
  endfunction

  task automatic wr(input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic wait_ack(input logic old);
    for (int k = 0; k < 100; k++) begin
      @(negedge clk);
      if (rd_data[5] !== old) break;
    end
  endtask

  task automatic measure(output int per, output int hi);
    for (int k = 0; k < 100; k++) begin
      @(negedge clk);
      if (clk_en_o) break;
    end
    per = 1; hi = int'(div_clk_o);
    for (int j = 0; j < 100; j++) begin
      @(negedge clk);
      if (clk_en_o) break;
      per++; hi += int'(div_clk_o);
    end
  endtask

  initial begin
    int per, hi, t0, n;
    logic old;
    repeat (3) @(negedge clk);
    chk(rd_data == 32'h4, "R1 reset word", int'(rd_data), 4);
    rst_n = 1'b1;

    // R5: force bit set, clk_req low for the whole table
    for (int i = 0; i < 8; i++) begin
      old = rd_data[5]; t0 = toggles;
      wr(word(VEC[i][15:11], 1'b1, 1'b0));
      chk(rd_data[4:0] == VEC[i][15:11], "R2 readback", int'(rd_data[4:0]), int'(VEC[i][15:11]));
      wait_ack(old);
      measure(per, hi);
      chk(per == int'(VEC[i][10:5]), "R2/R5 period", per, int'(VEC[i][10:5]));
      chk(hi == int'(VEC[i][4:0]), "R3 high phase", hi, int'(VEC[i][4:0]));
      chk(toggles == t0 + 1, "R4 one ack toggle", toggles - t0, 1);
    end

    // R4: same factor again, no toggle
    t0 = toggles;
    wr(word(5'd5, 1'b1, 1'b0));
    repeat (15) @(negedge clk);
    chk(toggles == t0, "R4 unchanged factor", toggles - t0, 0);

    // R4: two writes inside one period
    measure(per, hi);
    t0 = toggles;
    wr(word(5'd3, 1'b1, 1'b0));
    wr(word(5'd9, 1'b1, 1'b0));
    measure(per, hi);
    chk(per == 9, "R4 last write wins", per, 9);
    chk(toggles == t0 + 1, "R4 single toggle", toggles - t0, 1);

    // R6: request mode, no request
    wr(word(5'd5, 1'b0, 1'b0));
    n = 0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk); n = k + 1;
      if (rd_data[9]) break;
    end
    chk(n <= 9, "R6 stop latency", n, 9);
    n = 0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (clk_en_o || !rd_data[9]) n++;
    end
    chk(n == 0, "R6 no pulse while stopped", n, 0);

    // R7: restart at a boundary
    @(negedge clk); clk_req = 1'b1;
    n = 0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk); n = k + 1;
      if (clk_en_o) break;
    end
    chk(n >= 1 && n <= 5, "R7 restart latency", n, 5);
    measure(per, hi);
    chk(per == 5, "R7 period", per, 5);

    // R8: powered down, restart next cycle with full period
    clk_req = 1'b0;
    wr(word(5'd5, 1'b0, 1'b1));
    repeat (12) @(negedge clk);
    chk(rd_data[9] == 1'b1, "R8 stopped", int'(rd_data[9]), 1);
    clk_req = 1'b1;
    @(negedge clk);
    chk(clk_en_o == 1'b1, "R8 immediate pulse", int'(clk_en_o), 1);
    per = 0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk); per++;
      if (clk_en_o) break;
    end
    chk(per == 5, "R8 full first period", per, 5);

    // R10: factor change while powered down
    clk_req = 1'b0;
    repeat (12) @(negedge clk);
    t0 = toggles;
    wr(word(5'd6, 1'b0, 1'b1));
    repeat (3) @(negedge clk);
    chk(toggles == t0 + 1, "R10 ack while stopped", toggles - t0, 1);
    chk(rd_data[9] == 1'b1, "R10 still stopped", int'(rd_data[9]), 1);
    clk_req = 1'b1;
    measure(per, hi);
    measure(per, hi);
    chk(per == 6, "R10 new period", per, 6);

    // R9: reserved bits
    wr(32'hFFFF_FFFF);
    chk((rd_data & ~32'h0000_133F) == 0, "R9 reserved zero", int'(rd_data & ~32'h0000_133F), 0);
    chk(rd_data[4:0] == 5'd31 && rd_data[8] && rd_data[12], "R9 fields kept",
        int'(rd_data[12:0] & 13'h111F), 32'h111F);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #1_000_000;
    n_run++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule